// File: doc/BRIEF.md
# Converter Control and Result Register Block

This block is the processor-side register front end of a four-input, 10-bit converter. Software uses a mode register to start and enable conversions and a channel register to pick the input. The finished result can be read either as a full left-aligned word or as its top eight bits. A small digital engine stands in for the analog part. It counts a fixed number of clock cycles, then takes the value on `code_i` as the result of that conversion and raises a one-cycle interrupt.

The main job of the block is to settle what happens when a conversion ends in the same cycle as bus traffic:
- A result read in that cycle sees the old value. The new value is parked and lands on the first later cycle that has no result read.
- A mode or channel write in that cycle wins outright. The result is discarded and no interrupt is raised.

A stop input halts the engine whenever it is high.

Top module: `adc_ctrl_regs`

## Requirements
- R1: The mode register sits at address 0. Bit 7 is start and bit 0 is enable. It reads back with only those two bits; all other bits read as zero. The engine runs only while both bits are set and `stop_i` is low.
- R2: The channel register sits at address 1 and holds bits [1:0]. `ch_sel_o` shows the stored value, and a read returns it in bits [1:0] with all other bits zero.
- R3: Once running, a conversion lasts 14 clock cycles. At its last cycle, `code_i` is captured as the result. Conversions repeat back to back for as long as the engine keeps running.
- R4: A result read is a read at address 2 or 3. If a result read falls in the last cycle of a conversion, it returns the old value. The new value is committed on the first following cycle with no result read; if a newer conversion ends first, the newer value replaces it.
- R5: If a write to address 0 or 1 falls in the last cycle of a conversion, the write takes effect, the result stays unchanged and no interrupt is raised. Such a write also discards a parked result.
- R6: While `stop_i` is high, no conversion advances, and the engine restarts from cycle 0 once `stop_i` falls.
- R7: Address 2 returns the 10-bit result in bits [15:6], with bits [5:0] zero. Address 3 returns result bits [9:2] in bits [7:0], with the upper bits zero.
- R8: `eoc_irq_o` is high for exactly the cycle in which the new result first reads back, and it is low at all other times.
- R9: A write to address 0 or 1 during a conversion aborts it. The next conversion then counts from cycle 0.
- R10: Writes to addresses 2 and 3 change nothing.
- R11: After reset, every register reads zero and `eoc_irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stop_i | input | 1 | Stop-mode request; halts the engine |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 16 | Read data for the current address |
| code_i | input | 10 | Digital code from the converter model |
| ch_sel_o | output | 2 | Selected input channel |
| eoc_irq_o | output | 1 | Conversion-end interrupt pulse |

## Verification
A wrong cycle counter shows up as a shifted or missing interrupt. This can be seen at `eoc_irq_o` within one conversion period, which is 14 cycles. A fault in the parked-result path shows up as a stale or early value at address 2 or 3, and as an interrupt in the wrong cycle, on the first cycle after the reads stop. A collision that is settled the wrong way changes the result word or raises an interrupt in the cycle right after the colliding access. The bench drives every cycle against a reference model, so each of these faults is caught within one cycle of the point where it becomes visible.

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs #(
  parameter int RES_W       = 10,
  parameter int CONV_CYCLES = 14,
  parameter int NUM_CH      = 4,
  parameter int DATA_W      = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stop_i,
  input  logic                      bus_wr_i,
  input  logic                      bus_rd_i,
  input  logic [1:0]                bus_addr_i,
  input  logic [7:0]                bus_wdata_i,
  output logic [DATA_W-1:0]         bus_rdata_o,
  input  logic [RES_W-1:0]          code_i,
  output logic [$clog2(NUM_CH)-1:0] ch_sel_o,
  output logic                      eoc_irq_o
);
  localparam int CH_W  = $clog2(NUM_CH);
  localparam int CNT_W = $clog2(CONV_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);
  localparam logic [1:0] A_MODE = 2'd0, A_CHAN = 2'd1, A_FULL = 2'd2, A_HIGH = 2'd3;

  logic             start_q, en_q;
  logic [CH_W-1:0]  sel_q;
  logic [CNT_W-1:0] tick_q;
  logic [RES_W-1:0] res_q, hold_d;
  logic             hold_v, irq_q;

  wire ctl_wr     = bus_wr_i && (bus_addr_i == A_MODE || bus_addr_i == A_CHAN);
  wire res_rd     = bus_rd_i && bus_addr_i[1];
  wire run        = start_q && en_q && !stop_i;
  wire conv_end   = run && tick_q == LAST;
  wire commit_new = conv_end && !ctl_wr && !res_rd;
  wire park       = conv_end && !ctl_wr && res_rd;
  wire commit_old = hold_v && !ctl_wr && !res_rd && !commit_new;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      en_q    <= 1'b0;
      sel_q   <= '0;
    end else if (bus_wr_i) begin
      if (bus_addr_i == A_MODE) begin
        start_q <= bus_wdata_i[7];
        en_q    <= bus_wdata_i[0];
      end
      if (bus_addr_i == A_CHAN) sel_q <= bus_wdata_i[CH_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           tick_q <= '0;
    else if (ctl_wr || !run || conv_end)  tick_q <= '0;
    else                                  tick_q <= tick_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q  <= '0;
      hold_d <= '0;
      hold_v <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= commit_new || commit_old;
      if (commit_new)      res_q <= code_i;
      else if (commit_old) res_q <= hold_d;
      if (ctl_wr) hold_v <= 1'b0;
      else if (park) begin
        hold_v <= 1'b1;
        hold_d <= code_i;
      end else if (commit_new || commit_old) hold_v <= 1'b0;
    end
  end

  always_comb begin
    unique case (bus_addr_i)
      A_MODE:  bus_rdata_o = DATA_W'({start_q, 6'b0, en_q});
      A_CHAN:  bus_rdata_o = DATA_W'(sel_q);
      A_FULL:  bus_rdata_o = {res_q, {(DATA_W-RES_W){1'b0}}};
      default: bus_rdata_o = DATA_W'(res_q[RES_W-1 -: 8]);
    endcase
  end

  assign ch_sel_o  = sel_q;
  assign eoc_irq_o = irq_q;

  p_ctl_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> !eoc_irq_o);
  p_read_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_rd |=> $stable(res_q));
  p_stop_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> tick_q == '0);
  p_irq_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_irq_o |-> $past(!res_rd && !ctl_wr));
  p_tick_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q <= LAST);
  p_disabled_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> tick_q == '0);
endmodule

// File: tb/test_adc_ctrl_regs.sv
module test_adc_ctrl_regs;
  localparam int CLK_PERIOD = 10;
  localparam int LAST = 13;

  logic        clk = 1'b0, rst_n = 1'b0, stop_i = 1'b0;
  logic        bus_wr_i = 1'b0, bus_rd_i = 1'b0;
  logic [1:0]  bus_addr_i = '0;
  logic [7:0]  bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic [9:0]  code_i = '0;
  logic [1:0]  ch_sel_o;
  logic        eoc_irq_o;

  adc_ctrl_regs i_adc_ctrl_regs (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0, checks = 0, cycles = 0;
  logic m_start = 0, m_en = 0, m_pv = 0, m_irq = 0;
  logic [1:0] m_chan = 0;
  logic [9:0] m_res = 0, m_pd = 0;
  int m_tick = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return {8'b0, m_start, 6'b0, m_en};
      2'd1: return {14'b0, m_chan};
      2'd2: return {m_res, 6'b0};
      default: return {8'b0, m_res[9:2]};
    endcase
  endfunction

  task automatic step(input bit wr, input bit rd, input logic [1:0] a,
                      input logic [7:0] wd, input bit stp, input logic [9:0] code,
                      input string tag);
    bit ctl, rrd, run, fin, cnew, cold;
    @(negedge clk);
    bus_wr_i = wr; bus_rd_i = rd; bus_addr_i = a; bus_wdata_i = wd;
    stop_i = stp; code_i = code;
    #1;
    chk(eoc_irq_o == m_irq, {tag, " R8 irq"}, eoc_irq_o, m_irq);
    chk(ch_sel_o == m_chan, {tag, " R2 ch_sel"}, ch_sel_o, m_chan);
    if (rd) chk(bus_rdata_o == exp_rd(a), {tag, " R7 rdata"}, bus_rdata_o, exp_rd(a));
    @(posedge clk);
    ctl  = wr && (a < 2);
    rrd  = rd && a[1];
    run  = m_start && m_en && !stp;
    fin  = run && m_tick == LAST;
    cnew = fin && !ctl && !rrd;
    cold = m_pv && !ctl && !rrd && !cnew;
    m_irq = cnew || cold;
    if (cnew) m_res = code; else if (cold) m_res = m_pd;
    if (ctl) m_pv = 0;
    else if (fin && rrd) begin m_pv = 1; m_pd = code; end
    else if (cnew || cold) m_pv = 0;
    if (ctl || !run || fin) m_tick = 0; else m_tick++;
    if (wr && a == 0) begin m_start = wd[7]; m_en = wd[0]; end
    if (wr && a == 1) m_chan = wd[1:0];
  endtask

  task automatic idle_to_end(input string tag);
    for (int i = 0; i < 40 && m_tick != LAST; i++) step(0, 0, 0, 0, 0, 10'($urandom), tag);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 4; a++) step(0, 1, 2'(a), 0, 0, 0, "R11 reset");
    step(1, 0, 0, 8'h7e, 0, 0, "R1"); step(0, 1, 0, 0, 0, 0, "R1 mask");
    step(1, 0, 1, 8'hfe, 0, 0, "R2"); step(0, 1, 1, 0, 0, 0, "R2 read");
    step(1, 0, 0, 8'h81, 0, 0, "R3 start");
    for (int i = 0; i < 40; i++) step(0, i % 3 == 0, 2'(2 + i % 2), 0, 0, 10'h155 + 10'(i), "R3 run");
    step(1, 0, 2, 8'hff, 0, 0, "R10"); step(1, 0, 3, 8'h00, 0, 0, "R10");
    step(0, 1, 2, 0, 0, 0, "R10 read");
    idle_to_end("R4");
    step(0, 1, 2, 0, 0, 10'h3a5, "R4 collide");
    step(0, 1, 3, 0, 0, 10'h011, "R4 held");
    step(0, 0, 0, 0, 0, 10'h022, "R4 commit");
    step(0, 1, 2, 0, 0, 0, "R4 new");
    idle_to_end("R5");
    step(1, 0, 1, 8'h03, 0, 10'h2aa, "R5 collide");
    for (int i = 0; i < 5; i++) step(0, 1, 2, 0, 0, 0, "R5 kept");
    idle_to_end("R5b");
    step(0, 1, 3, 0, 0, 10'h0f0, "R5 park");
    step(1, 0, 0, 8'h81, 0, 0, "R5 drop");
    step(0, 1, 2, 0, 0, 0, "R5 dropped");
    for (int i = 0; i < 7; i++) step(0, 0, 0, 0, 0, 0, "R9");
    step(1, 0, 1, 8'h01, 0, 0, "R9 abort");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 10'h1c3, "R9 restart");
    for (int i = 0; i < 30; i++) step(0, 1, 2, 0, 1, 10'h3ff, "R6 stop");
    for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, 10'h099, "R6 resume");
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] wd;
      wd = ($urandom % 4 != 0) ? 8'h81 : 8'($urandom);
      step(($urandom % 10) == 0, ($urandom % 2) == 0, 2'($urandom),
           wd, ($urandom % 20) == 0, 10'($urandom), "R3 rand");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule